// File: doc/BRIEF.md
# Outstanding Miss Tracker

This block tracks cache misses that have been sent to the next memory level and not yet answered, so that the cache can keep serving hits, and can take further misses, while earlier ones are in flight. Each tracker slot holds the block address that missed, the cache frame the returning block will be written into, and a short list of requester tags waiting on that block.

A new miss is looked up against every busy slot in the same cycle. A miss to a block that is already outstanding joins that slot's waiter list and sends no second request. A miss whose frame is already promised to a different outstanding block is held off, as is a miss that finds no free slot or a full waiter list. Otherwise a free slot is claimed and a request, tagged with the slot number, goes out in that cycle. When the next level answers with a slot number, the block reports the frame, the address and every waiting tag in that cycle, and the slot becomes free at the following clock edge.

Top module: `mshr_file`

## Requirements
- R1: After synchronous reset every slot is free; with no miss and no fill presented, miss_accept, miss_stall, req_valid and done_valid are all 0 and stall_cause is 0.
- R2: A miss to a block that is not outstanding, with a free slot and no frame clash, is accepted in the same cycle with miss_merged 0 and miss_slot equal to the lowest-numbered free slot.
- R3: req_valid is 1 exactly in the cycle a slot is claimed, carrying the miss block address on req_addr and the claimed slot on req_slot; a merged or stalled miss raises no request.
- R4: A miss whose block address equals that of a busy slot merges: miss_accept 1, miss_merged 1, miss_slot is that slot, no request, and its tag is appended to the slot's waiter list. Merging is checked first, so it succeeds even when every slot is busy.
- R5: A miss that would merge into a slot whose waiter list already holds TARGETS tags stalls with stall_cause 3.
- R6: A miss to a new block whose frame equals the frame of a busy slot stalls with stall_cause 2.
- R7: A miss to a new block with no frame clash and no free slot stalls with stall_cause 1.
- R8: Cycles with no miss presented (hit traffic) neither raise outputs nor change any slot's contents.
- R9: A fill naming a busy slot raises done_valid in the same cycle with that slot's frame and block address; waiter k appears at done_ids bits [k*ID_W +: ID_W] in arrival order and done_mask bit k marks it valid.
- R10: The slot being completed is freed at the end of that cycle: in that cycle it is neither matched by a miss nor reused, and in the next cycle it can be claimed.
- R11: A fill naming a free slot is ignored: done_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is presented this cycle |
| miss_addr | input | ADDR_W | Block address of the miss |
| miss_frame | input | FRAME_W | Cache frame chosen for the fill |
| miss_id | input | ID_W | Tag of the requesting instruction |
| miss_accept | output | 1 | Miss taken (new slot or merge) |
| miss_merged | output | 1 | Miss joined an outstanding slot |
| miss_stall | output | 1 | Miss refused; retry later |
| stall_cause | output | 2 | 0 none, 1 no free slot, 2 frame clash, 3 waiter list full |
| miss_slot | output | IDX_W | Slot that took the miss |
| req_valid | output | 1 | Request to next level |
| req_addr | output | ADDR_W | Requested block address |
| req_slot | output | IDX_W | Slot tag carried by the request |
| fill_valid | input | 1 | Next level answers |
| fill_slot | input | IDX_W | Slot named by the answer |
| done_valid | output | 1 | Completion reported |
| done_addr | output | ADDR_W | Block address of the completed slot |
| done_frame | output | FRAME_W | Frame to write the block into |
| done_ids | output | TARGETS*ID_W | Waiting tags, packed by arrival order |
| done_mask | output | TARGETS | Valid bits for done_ids |

## Verification
On every cycle the assertions check that a request only accompanies a fresh claim and leaves that slot busy, that accept and stall never coincide, that a completion only follows a fill and frees its slot at the next edge, and that idle cycles leave slot occupancy unchanged. Whether the right slot was chosen, whether the stall cause matches the clash found, and whether merged tags come back in order with the right frame and address can only be shown by the bench's scripted sequence of fills, merges and refusals, which compares each completion with a queued expectation.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

    typedef enum logic [1:0] {
        STALL_NONE    = 2'd0,
        STALL_FULL    = 2'd1,
        STALL_FRAME   = 2'd2,
        STALL_TARGETS = 2'd3
    } stall_e;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_ALLOC = 2'd1,
        ACT_MERGE = 2'd2,
        ACT_HOLD  = 2'd3
    } miss_act_e;

    function automatic int unsigned ones32(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n = n + int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/mshr_pick.sv
module mshr_pick #(
    parameter int N     = 4,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry #(
    parameter int ADDR_W  = 26,
    parameter int FRAME_W = 8,
    parameter int ID_W    = 5,
    parameter int TARGETS = 2,
    localparam int TW     = (TARGETS > 1) ? $clog2(TARGETS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    alloc,
    input  logic                    merge,
    input  logic                    retire,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic [FRAME_W-1:0]      in_frame,
    input  logic [ID_W-1:0]         in_id,
    output logic                    vld,
    output logic                    addr_hit,
    output logic                    frame_hit,
    output logic                    tgt_full,
    output logic [ADDR_W-1:0]       q_addr,
    output logic [FRAME_W-1:0]      q_frame,
    output logic [TARGETS*ID_W-1:0] q_ids,
    output logic [TARGETS-1:0]      q_mask
);
    import mshr_pkg::*;

    logic [ID_W-1:0] id_q [TARGETS];
    logic [TW-1:0]   nxt;

    always_comb begin
        nxt = TW'(ones32(32'(q_mask)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld     <= 1'b0;
            q_mask  <= '0;
            q_addr  <= '0;
            q_frame <= '0;
            for (int k = 0; k < TARGETS; k++) id_q[k] <= '0;
        end else if (retire) begin
            vld    <= 1'b0;
            q_mask <= '0;
        end else if (alloc) begin
            vld     <= 1'b1;
            q_addr  <= in_addr;
            q_frame <= in_frame;
            id_q[0] <= in_id;
            q_mask  <= TARGETS'(1);
        end else if (merge) begin
            id_q[nxt]   <= in_id;
            q_mask[nxt] <= 1'b1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < TARGETS; g++) begin : g_ids
            assign q_ids[g*ID_W +: ID_W] = id_q[g];
        end
    endgenerate

    assign addr_hit  = vld && !retire && (q_addr == in_addr);
    assign frame_hit = vld && !retire && (q_frame == in_frame);
    assign tgt_full  = &q_mask;
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 26,
    parameter int FRAME_W = 8,
    parameter int ID_W    = 5,
    parameter int TARGETS = 2,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    miss_valid,
    input  logic [ADDR_W-1:0]       miss_addr,
    input  logic [FRAME_W-1:0]      miss_frame,
    input  logic [ID_W-1:0]         miss_id,
    output logic                    miss_accept,
    output logic                    miss_merged,
    output logic                    miss_stall,
    output logic [1:0]              stall_cause,
    output logic [IDX_W-1:0]        miss_slot,
    output logic                    req_valid,
    output logic [ADDR_W-1:0]       req_addr,
    output logic [IDX_W-1:0]        req_slot,
    input  logic                    fill_valid,
    input  logic [IDX_W-1:0]        fill_slot,
    output logic                    done_valid,
    output logic [ADDR_W-1:0]       done_addr,
    output logic [FRAME_W-1:0]      done_frame,
    output logic [TARGETS*ID_W-1:0] done_ids,
    output logic [TARGETS-1:0]      done_mask
);
    import mshr_pkg::*;

    logic [ENTRIES-1:0] vld, ahit, fhit, tfull, retire, alloc, merge;
    logic [ADDR_W-1:0]       e_addr  [ENTRIES];
    logic [FRAME_W-1:0]      e_frame [ENTRIES];
    logic [TARGETS*ID_W-1:0] e_ids   [ENTRIES];
    logic [TARGETS-1:0]      e_mask  [ENTRIES];

    logic             m_found, f_found;
    logic [IDX_W-1:0] m_idx, f_idx;
    miss_act_e        act;
    stall_e           cause;

    always_comb begin
        retire = '0;
        if (fill_valid) retire = vld & (ENTRIES'(1) << fill_slot);
    end

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_ent
            mshr_entry #(
                .ADDR_W(ADDR_W), .FRAME_W(FRAME_W),
                .ID_W(ID_W), .TARGETS(TARGETS)
            ) u_ent (
                .clk(clk), .rst(rst),
                .alloc(alloc[g]), .merge(merge[g]), .retire(retire[g]),
                .in_addr(miss_addr), .in_frame(miss_frame), .in_id(miss_id),
                .vld(vld[g]), .addr_hit(ahit[g]), .frame_hit(fhit[g]),
                .tgt_full(tfull[g]),
                .q_addr(e_addr[g]), .q_frame(e_frame[g]),
                .q_ids(e_ids[g]), .q_mask(e_mask[g])
            );
        end
    endgenerate

    mshr_pick #(.N(ENTRIES)) u_pick_match (.vec(ahit), .found(m_found), .idx(m_idx));
    mshr_pick #(.N(ENTRIES)) u_pick_free  (.vec(~vld), .found(f_found), .idx(f_idx));

    always_comb begin
        act   = ACT_IDLE;
        cause = STALL_NONE;
        if (miss_valid) begin
            if (m_found) begin
                if (tfull[m_idx]) begin
                    act   = ACT_HOLD;
                    cause = STALL_TARGETS;
                end else begin
                    act = ACT_MERGE;
                end
            end else if (|fhit) begin
                act   = ACT_HOLD;
                cause = STALL_FRAME;
            end else if (!f_found) begin
                act   = ACT_HOLD;
                cause = STALL_FULL;
            end else begin
                act = ACT_ALLOC;
            end
        end
    end

    always_comb begin
        alloc = '0;
        merge = '0;
        if (act == ACT_ALLOC) alloc = ENTRIES'(1) << f_idx;
        if (act == ACT_MERGE) merge = ENTRIES'(1) << m_idx;
    end

    assign miss_accept = (act == ACT_ALLOC) || (act == ACT_MERGE);
    assign miss_merged = (act == ACT_MERGE);
    assign miss_stall  = (act == ACT_HOLD);
    assign stall_cause = cause;
    assign miss_slot   = (act == ACT_MERGE) ? m_idx : f_idx;

    assign req_valid = (act == ACT_ALLOC);
    assign req_addr  = miss_addr;
    assign req_slot  = f_idx;

    assign done_valid = |retire;
    assign done_addr  = e_addr[fill_slot];
    assign done_frame = e_frame[fill_slot];
    assign done_ids   = e_ids[fill_slot];
    assign done_mask  = done_valid ? e_mask[fill_slot] : '0;
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               miss_valid,
    input logic               miss_accept,
    input logic               miss_merged,
    input logic               miss_stall,
    input logic               req_valid,
    input logic [IDX_W-1:0]   req_slot,
    input logic               fill_valid,
    input logic [IDX_W-1:0]   fill_slot,
    input logic               done_valid,
    input logic [ENTRIES-1:0] entry_vld
);
    a_r1_reset_frees: assert property (@(posedge clk) rst |=> (entry_vld == '0));

    a_r3_req_only_on_claim: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (miss_accept && !miss_merged));

    a_r2_claim_marks_busy: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> entry_vld[$past(req_slot)]);

    a_r5_accept_xor_stall: assert property (@(posedge clk) disable iff (rst)
        !(miss_accept && miss_stall));

    a_r8_idle_keeps_slots: assert property (@(posedge clk) disable iff (rst)
        (!miss_valid && !fill_valid) |=> $stable(entry_vld));

    a_r11_done_needs_fill: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> fill_valid);

    a_r10_done_frees: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !entry_vld[$past(fill_slot)]);
endmodule

bind mshr_file mshr_file_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .miss_valid(miss_valid),
    .miss_accept(miss_accept), .miss_merged(miss_merged), .miss_stall(miss_stall),
    .req_valid(req_valid), .req_slot(req_slot),
    .fill_valid(fill_valid), .fill_slot(fill_slot),
    .done_valid(done_valid), .entry_vld(vld)
);

// File: tb/test_mshr_file.sv
module test_mshr_file;
    localparam int AW = 26, FW = 8, IW = 5, NT = 2, NE = 4, XW = 2;

    typedef struct packed {
        logic [AW-1:0]    a;
        logic [FW-1:0]    f;
        logic [NT*IW-1:0] ids;
        logic [NT-1:0]    m;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1;
    logic miss_valid = 1'b0, fill_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic [FW-1:0] miss_frame = '0;
    logic [IW-1:0] miss_id = '0;
    logic [XW-1:0] fill_slot = '0;
    logic miss_accept, miss_merged, miss_stall, req_valid, done_valid;
    logic [1:0] stall_cause;
    logic [XW-1:0] miss_slot, req_slot;
    logic [AW-1:0] req_addr, done_addr;
    logic [FW-1:0] done_frame;
    logic [NT*IW-1:0] done_ids;
    logic [NT-1:0] done_mask;

    int compared = 0, mismatched = 0;
    bit finished = 0;
    exp_t expq[$];

    always #10 clk = ~clk;

    mshr_file #(.ENTRIES(NE), .ADDR_W(AW), .FRAME_W(FW), .ID_W(IW), .TARGETS(NT)) i_mshr_file (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_frame(miss_frame), .miss_id(miss_id),
        .miss_accept(miss_accept), .miss_merged(miss_merged), .miss_stall(miss_stall),
        .stall_cause(stall_cause), .miss_slot(miss_slot),
        .req_valid(req_valid), .req_addr(req_addr), .req_slot(req_slot),
        .fill_valid(fill_valid), .fill_slot(fill_slot),
        .done_valid(done_valid), .done_addr(done_addr), .done_frame(done_frame),
        .done_ids(done_ids), .done_mask(done_mask)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: completions compared against queued expectations.
    always @(negedge clk) begin
        #3;
        if (!rst && done_valid) begin
            if (expq.size() == 0) begin
                check("R11 unexpected completion", 64'(done_valid), 64'd0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check("R9 done_addr",  64'(done_addr),  64'(e.a));
                check("R9 done_frame", 64'(done_frame), 64'(e.f));
                check("R9 done_mask",  64'(done_mask),  64'(e.m));
                check("R9 done_ids",   64'(done_ids & {{IW{e.m[1]}}, {IW{e.m[0]}}}), 64'(e.ids));
            end
        end
    end

    task automatic step_miss(input logic [AW-1:0] a, input logic [FW-1:0] f, input logic [IW-1:0] id);
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = a; miss_frame = f; miss_id = id;
        fill_valid = 1'b0;
        #2;
    endtask

    task automatic step_idle();
        @(negedge clk);
        miss_valid = 1'b0; fill_valid = 1'b0;
        #2;
    endtask

    task automatic step_fill(input logic [XW-1:0] s, input bit expect_done, input exp_t e);
        @(negedge clk);
        miss_valid = 1'b0; fill_valid = 1'b1; fill_slot = s;
        if (expect_done) expq.push_back(e);
        #2;
    endtask

    initial begin
        #(20 * 5000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        exp_t e;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        step_idle();
        check("R1 accept", 64'(miss_accept), 0);
        check("R1 stall", 64'(miss_stall), 0);
        check("R1 req", 64'(req_valid), 0);
        check("R1 done", 64'(done_valid), 0);
        check("R1 cause", 64'(stall_cause), 0);
        // R2 R3 fresh claim of block A
        step_miss(26'h100, 8'd3, 5'd1);
        check("R2 accept", 64'(miss_accept), 1);
        check("R2 merged", 64'(miss_merged), 0);
        check("R2 slot", 64'(miss_slot), 0);
        check("R3 req_valid", 64'(req_valid), 1);
        check("R3 req_addr", 64'(req_addr), 64'h100);
        check("R3 req_slot", 64'(req_slot), 0);
        // R4 merge into A
        step_miss(26'h100, 8'd3, 5'd2);
        check("R4 accept", 64'(miss_accept), 1);
        check("R4 merged", 64'(miss_merged), 1);
        check("R4 slot", 64'(miss_slot), 0);
        check("R4 no request", 64'(req_valid), 0);
        // R5 waiter list full
        step_miss(26'h100, 8'd3, 5'd3);
        check("R5 stall", 64'(miss_stall), 1);
        check("R5 cause", 64'(stall_cause), 3);
        check("R5 no request", 64'(req_valid), 0);
        // R6 frame clash with a different block
        step_miss(26'h200, 8'd3, 5'd4);
        check("R6 stall", 64'(miss_stall), 1);
        check("R6 cause", 64'(stall_cause), 2);
        // fill remaining slots
        step_miss(26'h300, 8'd4, 5'd5);
        check("R2 slot1", 64'(miss_slot), 1);
        step_miss(26'h400, 8'd5, 5'd6);
        check("R2 slot2", 64'(miss_slot), 2);
        step_miss(26'h500, 8'd6, 5'd8);
        check("R3 req_slot3", 64'(req_slot), 3);
        // R7 no free slot
        step_miss(26'h600, 8'd7, 5'd9);
        check("R7 stall", 64'(miss_stall), 1);
        check("R7 cause", 64'(stall_cause), 1);
        check("R7 no request", 64'(req_valid), 0);
        // R8 idle cycle has no effect
        step_idle();
        check("R8 accept", 64'(miss_accept), 0);
        check("R8 stall", 64'(miss_stall), 0);
        check("R8 req", 64'(req_valid), 0);
        // R4 merge while every slot is busy
        step_miss(26'h300, 8'd4, 5'd7);
        check("R4 merge when full", 64'(miss_merged), 1);
        check("R4 merge slot", 64'(miss_slot), 1);
        // R9 R10 complete A while B (frame 3) is presented
        e = '{a: 26'h100, f: 8'd3, ids: {5'd2, 5'd1}, m: 2'b11};
        step_fill(2'd0, 1'b1, e);
        miss_valid = 1'b1; miss_addr = 26'h200; miss_frame = 8'd3; miss_id = 5'd4;
        #1;
        check("R9 done_valid", 64'(done_valid), 1);
        check("R10 retiring slot not reused", 64'(stall_cause), 1);
        check("R10 no request", 64'(req_valid), 0);
        // R10 freed slot reclaimed next cycle
        step_miss(26'h200, 8'd3, 5'd4);
        check("R10 reclaim accept", 64'(miss_accept), 1);
        check("R10 reclaim slot", 64'(req_slot), 0);
        // R9 merged completion on slot1 (R8 showed contents kept)
        e = '{a: 26'h300, f: 8'd4, ids: {5'd7, 5'd5}, m: 2'b11};
        step_fill(2'd1, 1'b1, e);
        check("R9 done slot1", 64'(done_valid), 1);
        // R11 fill to now-free slot1
        e = '0;
        step_fill(2'd1, 1'b0, e);
        check("R11 ignored", 64'(done_valid), 0);
        // R9 single-waiter completion
        e = '{a: 26'h400, f: 8'd5, ids: {5'd0, 5'd6}, m: 2'b01};
        step_fill(2'd2, 1'b1, e);
        check("R9 single mask", 64'(done_mask), 64'b01);
        step_idle();
        step_idle();
        check("R9 all completions seen", 64'(expq.size()), 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule